// File: doc/BRIEF.md
# Debug Entry Cause Register

This block keeps a 32-bit record of the reasons a processor core was sent into debug mode. Each supported exception or event source has its own bit. Hardware sets a bit when its event arrives, and the bit stays set until software reads the register. Bits are numbered MSB-first, so bit 0 is the most significant bit of the word.

A machine check goes to one of two cause bits, chosen by the machine-check-enable status from the core's machine state. A separate per-cause enable word and a global debug enable decide whether a recorded event also asks the core to enter debug mode. When a check stop is not allowed to enter debug mode, the block asks for a check-stop halt instead. A simple load port writes the enable word.

Software sees the register through a read-only special-purpose register access at number 148. A read returns the current contents and clears them. Writes are not accepted.

Top module: `dbg_cause_reg`

## Requirements
- R1: While reset is held and when it is released, the cause word is 0x00000000 and both `dbg_req` and `chkstop_req` are low.
- R2: A read is an access with `spr_req`=1, `spr_we`=0 and `spr_addr`=148. It loads the cause word into `spr_rdata`, which is visible one cycle later. It also clears every cause bit, so a following read returns 0. `spr_rdata` holds its value until the next read.
- R3: A write (`spr_req`=1, `spr_we`=1), at any address and for any data, leaves the cause word unchanged. A read at any address other than 148 neither clears the word nor changes `spr_rdata`.
- R4: MSB-first bits 0, 4, 5, 11, 12, 15, 16, 17 and 23 to 27 always read as 0, even when all events fire and all enable bits are loaded with ones.
- R5: `evt_mchk` with `msr_me`=0 sets bit 2, the check-stop cause. `evt_mchk` with `msr_me`=1 sets bit 3, the machine-check cause. `evt_rst` sets bit 1. `evt_ext` sets bit 6. `evt_align` sets bit 7. A bit at MSB-first position k is word bit 31-k.
- R6: `chkstop_req` is high in the cycle after a cycle with `evt_mchk`=1 and `msr_me`=0, unless both `dbg_en` and enable bit 2 were set in that cycle. It is low in every other cycle.
- R7: `dbg_req` is high in the cycle after a cycle in which `dbg_en` is 1 and at least one event sets a cause bit whose enable bit (same MSB-first position) is 1. It is low in every other cycle, so one isolated event gives a one-cycle pulse.
- R8: Events in the same cycle are all recorded. Events in different cycles accumulate until a read.
- R9: When an event and a clearing read fall in the same cycle, the read returns the old word and the new event's bit is set afterwards.
- R10: `exc_evt[i]` for i = 0..13 sets MSB-first bits 8, 9, 10, 13, 14, 18, 19, 20, 21, 22, 28, 29, 30, 31, in that order.
- R11: A load (`den_load`=1) replaces the enable word, and it applies from the next cycle. A cause whose enable bit is 0 is still recorded, but it does not raise `dbg_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_rst | input | 1 | System reset event |
| evt_mchk | input | 1 | Machine check event |
| msr_me | input | 1 | Machine-check-enable status of the core |
| evt_ext | input | 1 | External interrupt event |
| evt_align | input | 1 | Alignment exception event |
| exc_evt | input | 14 | Other exception and breakpoint events |
| dbg_en | input | 1 | Global debug enable |
| den_load | input | 1 | Load strobe for the enable word |
| den_wdata | input | 32 | Enable word, MSB-first like the cause word |
| spr_req | input | 1 | Special-purpose register access strobe |
| spr_we | input | 1 | Access is a write |
| spr_addr | input | 10 | Special-purpose register number |
| spr_rdata | output | 32 | Read data, registered |
| dbg_req | output | 1 | Debug-mode entry request pulse |
| chkstop_req | output | 1 | Check-stop halt request |

## Verification
The two functions that can meet in one cycle are a hardware event setting a bit and a software read clearing the register. The bench first records one cause. It then issues the read in the same cycle as a different event. The returned word must hold only the first cause, and the next read must hold only the second. The bench also checks that a write or a read at another register number, issued while the register holds a cause, leaves that cause in place.

// File: rtl/dbg_cause_pkg.sv
package dbg_cause_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_MISC = 14;

    // MSB-first positions of the fixed causes
    localparam int POS_RST    = 1;
    localparam int POS_CHKSTP = 2;
    localparam int POS_MCHK   = 3;
    localparam int POS_EXT    = 6;
    localparam int POS_ALIGN  = 7;

    // MSB-first positions fed by exc_evt[i]; software decodes these
    localparam int MISC_POS [NUM_MISC] = '{8, 9, 10, 13, 14, 18, 19, 20, 21, 22, 28, 29, 30, 31};

    typedef struct packed {
        logic                rst;
        logic                mchk;
        logic                me;
        logic                ext;
        logic                align;
        logic [NUM_MISC-1:0] misc;
    } cause_evt_t;

    // MSB-first position -> vector index
    function automatic int vidx(input int pos);
        return DATA_W - 1 - pos;
    endfunction

    // Bits that carry a cause; all others are reserved
    function automatic logic [DATA_W-1:0] valid_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[vidx(POS_RST)]    = 1'b1;
        m[vidx(POS_CHKSTP)] = 1'b1;
        m[vidx(POS_MCHK)]   = 1'b1;
        m[vidx(POS_EXT)]    = 1'b1;
        m[vidx(POS_ALIGN)]  = 1'b1;
        for (int i = 0; i < NUM_MISC; i++) begin
            m[vidx(MISC_POS[i])] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dbg_cause_decode.sv
module dbg_cause_decode
    import dbg_cause_pkg::*;
(
    input  cause_evt_t        ev,
    output logic [DATA_W-1:0] set_vec,
    output logic              chkstop_evt
);

    always_comb begin
        set_vec = '0;
        if (ev.rst) begin
            set_vec[vidx(POS_RST)] = 1'b1;
        end
        if (ev.mchk) begin
            if (ev.me) begin
                set_vec[vidx(POS_MCHK)] = 1'b1;
            end else begin
                set_vec[vidx(POS_CHKSTP)] = 1'b1;
            end
        end
        if (ev.ext) begin
            set_vec[vidx(POS_EXT)] = 1'b1;
        end
        if (ev.align) begin
            set_vec[vidx(POS_ALIGN)] = 1'b1;
        end
        for (int i = 0; i < NUM_MISC; i++) begin
            if (ev.misc[i]) begin
                set_vec[vidx(MISC_POS[i])] = 1'b1;
            end
        end
    end

    assign chkstop_evt = ev.mchk & ~ev.me;

endmodule

// File: rtl/dbg_enable_reg.sv
module dbg_enable_reg
    import dbg_cause_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] den_q
);

    localparam logic [DATA_W-1:0] VALID = valid_mask();

    typedef struct packed {
        logic [DATA_W-1:0] den;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.den = wdata & VALID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign den_q = st_q.den;

endmodule

// File: rtl/dbg_req_gen.sv
module dbg_req_gen
    import dbg_cause_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] den,
    input  logic              dbg_en,
    input  logic              chkstop_evt,
    output logic              dbg_req,
    output logic              chkstop_req
);

    typedef struct packed {
        logic dbg_req;
        logic chkstop;
    } req_state_t;

    req_state_t st_d, st_q;
    logic       enabled_hit;
    logic       cs_to_debug;

    always_comb begin
        enabled_hit   = dbg_en & (|(set_vec & den));
        cs_to_debug   = dbg_en & den[vidx(POS_CHKSTP)];
        st_d.dbg_req  = enabled_hit;
        st_d.chkstop  = chkstop_evt & ~cs_to_debug;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_req     = st_q.dbg_req;
    assign chkstop_req = st_q.chkstop;

endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg
    import dbg_cause_pkg::*;
#(
    parameter int SPR_AW    = 10,
    parameter int CAUSE_SPR = 148
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_rst,
    input  logic                evt_mchk,
    input  logic                msr_me,
    input  logic                evt_ext,
    input  logic                evt_align,
    input  logic [NUM_MISC-1:0] exc_evt,
    input  logic                dbg_en,
    input  logic                den_load,
    input  logic [DATA_W-1:0]   den_wdata,
    input  logic                spr_req,
    input  logic                spr_we,
    input  logic [SPR_AW-1:0]   spr_addr,
    output logic [DATA_W-1:0]   spr_rdata,
    output logic                dbg_req,
    output logic                chkstop_req
);

    localparam logic [SPR_AW-1:0] SPR_NUM = SPR_AW'(CAUSE_SPR);

    typedef struct packed {
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    cause_evt_t        ev;
    logic [DATA_W-1:0] set_vec;
    logic              chkstop_evt;
    logic [DATA_W-1:0] den_q;
    logic              rd_hit;
    logic [DATA_W-1:0] cause_q;
    reg_state_t        st_d, st_q;

    assign ev = '{rst: evt_rst, mchk: evt_mchk, me: msr_me,
                  ext: evt_ext, align: evt_align, misc: exc_evt};

    dbg_cause_decode u_decode (
        .ev          (ev),
        .set_vec     (set_vec),
        .chkstop_evt (chkstop_evt)
    );

    dbg_enable_reg u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (den_load),
        .wdata (den_wdata),
        .den_q (den_q)
    );

    dbg_req_gen u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_vec     (set_vec),
        .den         (den_q),
        .dbg_en      (dbg_en),
        .chkstop_evt (chkstop_evt),
        .dbg_req     (dbg_req),
        .chkstop_req (chkstop_req)
    );

    // Writes are never decoded: the register is read-only
    assign rd_hit = spr_req & ~spr_we & (spr_addr == SPR_NUM);

    always_comb begin
        st_d = st_q;
        if (rd_hit) begin
            st_d.rdata = st_q.cause;
            st_d.cause = '0;
        end
        // a set in the clearing cycle survives
        st_d.cause = st_d.cause | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_q   = st_q.cause;
    assign spr_rdata = st_q.rdata;

endmodule

// File: rtl/dbg_cause_chk.sv
module dbg_cause_chk
    import dbg_cause_pkg::*;
#(
    parameter int SPR_AW    = 10,
    parameter int CAUSE_SPR = 148
) (
    input logic                clk,
    input logic                rst_n,
    input logic                evt_rst,
    input logic                evt_mchk,
    input logic                msr_me,
    input logic                evt_ext,
    input logic                evt_align,
    input logic [NUM_MISC-1:0] exc_evt,
    input logic                dbg_en,
    input logic                spr_req,
    input logic                spr_we,
    input logic [SPR_AW-1:0]   spr_addr,
    input logic [DATA_W-1:0]   spr_rdata,
    input logic                dbg_req,
    input logic                chkstop_req,
    input logic [DATA_W-1:0]   cause_q,
    input logic [DATA_W-1:0]   den_q
);

    localparam logic [DATA_W-1:0] RSVD = ~valid_mask();

    logic any_evt;
    logic rd_hit;

    assign any_evt = evt_rst | evt_mchk | evt_ext | evt_align | (|exc_evt);
    assign rd_hit  = spr_req & ~spr_we & (spr_addr == SPR_AW'(CAUSE_SPR));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cause_q == '0 && !dbg_req && !chkstop_req));

    assert_read_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> spr_rdata == $past(cause_q));

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !any_evt) |=> cause_q == '0);

    assert_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_req && spr_we && !any_evt) |=> $stable(cause_q));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_rdata & RSVD) == '0);

    assert_mchk_me1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mchk && msr_me) |=> cause_q[vidx(POS_MCHK)]);

    assert_mchk_me0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mchk && !msr_me) |=> cause_q[vidx(POS_CHKSTP)]);

    assert_chkstop_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mchk && !msr_me && !(dbg_en && den_q[vidx(POS_CHKSTP)])) |=> chkstop_req);

    assert_ext_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ext && dbg_en && den_q[vidx(POS_EXT)]) |=> dbg_req);

    assert_no_req_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |=> !dbg_req);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && evt_align) |=> cause_q[vidx(POS_ALIGN)]);

endmodule

bind dbg_cause_reg dbg_cause_chk #(
    .SPR_AW    (SPR_AW),
    .CAUSE_SPR (CAUSE_SPR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_rst     (evt_rst),
    .evt_mchk    (evt_mchk),
    .msr_me      (msr_me),
    .evt_ext     (evt_ext),
    .evt_align   (evt_align),
    .exc_evt     (exc_evt),
    .dbg_en      (dbg_en),
    .spr_req     (spr_req),
    .spr_we      (spr_we),
    .spr_addr    (spr_addr),
    .spr_rdata   (spr_rdata),
    .dbg_req     (dbg_req),
    .chkstop_req (chkstop_req),
    .cause_q     (cause_q),
    .den_q       (den_q)
);

// File: tb/dbg_cause_reg_tb.sv
module dbg_cause_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 13;
    localparam int MP [14]    = '{8, 9, 10, 13, 14, 18, 19, 20, 21, 22, 28, 29, 30, 31};

    // {rst, mchk, me, ext, align, misc[13:0], dbg_en, den_all_ones, exp_req, exp_cs}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,1'b1,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b1,1'b0,14'h0000,1'b0,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b0,1'b0,1'b1,14'h0000,1'b1,1'b0,1'b0,1'b0},
        {1'b0,1'b1,1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b0},
        {1'b0,1'b1,1'b0,1'b0,1'b0,14'h0000,1'b1,1'b0,1'b0,1'b1},
        {1'b0,1'b1,1'b0,1'b0,1'b0,14'h0000,1'b0,1'b1,1'b0,1'b1},
        {1'b0,1'b1,1'b1,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b0},
        {1'b0,1'b1,1'b1,1'b0,1'b0,14'h0000,1'b1,1'b0,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b0,1'b0,14'h0001,1'b1,1'b1,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b0,1'b0,14'h2000,1'b0,1'b1,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b1,1'b1,14'h3FFF,1'b1,1'b1,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_rst, evt_mchk, msr_me, evt_ext, evt_align;
    logic [13:0] exc_evt;
    logic        dbg_en, den_load;
    logic [31:0] den_wdata;
    logic        spr_req, spr_we;
    logic [9:0]  spr_addr;
    logic [31:0] spr_rdata;
    logic        dbg_req, chkstop_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cause_reg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_rst(evt_rst), .evt_mchk(evt_mchk),
        .msr_me(msr_me), .evt_ext(evt_ext), .evt_align(evt_align),
        .exc_evt(exc_evt), .dbg_en(dbg_en), .den_load(den_load),
        .den_wdata(den_wdata), .spr_req(spr_req), .spr_we(spr_we),
        .spr_addr(spr_addr), .spr_rdata(spr_rdata), .dbg_req(dbg_req),
        .chkstop_req(chkstop_req)
    );

    function automatic logic [31:0] bitk(int k);
        return 32'h8000_0000 >> k;
    endfunction

    function automatic logic [31:0] expect_word(logic r, logic m, logic me,
                                                logic x, logic a, logic [13:0] o);
        logic [31:0] w = '0;
        if (r) w |= bitk(1);
        if (m) w |= me ? bitk(3) : bitk(2);
        if (x) w |= bitk(6);
        if (a) w |= bitk(7);
        for (int i = 0; i < 14; i++) if (o[i]) w |= bitk(MP[i]);
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clr_evt();
        evt_rst = 0; evt_mchk = 0; msr_me = 0; evt_ext = 0; evt_align = 0; exc_evt = '0;
    endtask

    task automatic do_read(logic [9:0] addr);
        spr_req = 1; spr_we = 0; spr_addr = addr;
        @(negedge clk);
        spr_req = 0;
    endtask

    task automatic load_den(logic [31:0] d);
        den_load = 1; den_wdata = d;
        @(negedge clk);
        den_load = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [22:0] v;
        clr_evt();
        rst_n = 0; dbg_en = 0; den_load = 0; den_wdata = '0;
        spr_req = 0; spr_we = 0; spr_addr = '0;
        evt_ext = 1;                       // event during reset must not stick
        repeat (3) @(negedge clk);
        check("R1 dbg_req in reset", {31'b0, dbg_req}, 32'h0);
        check("R1 chkstop_req in reset", {31'b0, chkstop_req}, 32'h0);
        clr_evt();
        rst_n = 1;
        do_read(10'd148);
        check("R1 cause after reset", spr_rdata, 32'h0);

        // table walk: R5 R6 R7 R8 R10 R2 R4
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            dbg_en = v[3];
            load_den(v[2] ? 32'hFFFF_FFFF : 32'h0);
            evt_rst = v[22]; evt_mchk = v[21]; msr_me = v[20];
            evt_ext = v[19]; evt_align = v[18]; exc_evt = v[17:4];
            @(negedge clk);
            clr_evt();
            check("R7 dbg_req", {31'b0, dbg_req}, {31'b0, v[1]});
            check("R6 chkstop_req", {31'b0, chkstop_req}, {31'b0, v[0]});
            do_read(10'd148);
            check("R5/R10 cause word", spr_rdata,
                  expect_word(v[22], v[21], v[20], v[19], v[18], v[17:4]));
            check("R4 reserved bits", spr_rdata & 32'h8C19_C1F0, 32'h0);
            check("R7 pulse width", {31'b0, dbg_req}, 32'h0);
            do_read(10'd148);
            check("R2 cleared by read", spr_rdata, 32'h0);
        end

        // R3: write and foreign-address read leave the word
        dbg_en = 0;
        evt_ext = 1; @(negedge clk); clr_evt();
        spr_req = 1; spr_we = 1; spr_addr = 10'd148; @(negedge clk);
        spr_addr = 10'd147; @(negedge clk); spr_req = 0;
        do_read(10'd147);
        check("R3 foreign read keeps rdata", spr_rdata, 32'h0);
        do_read(10'd148);
        check("R3 write ignored", spr_rdata, bitk(6));

        // R8: accumulation across cycles
        evt_ext = 1; @(negedge clk); clr_evt();
        @(negedge clk);
        evt_align = 1; @(negedge clk); clr_evt();
        do_read(10'd148);
        check("R8 accumulate", spr_rdata, bitk(6) | bitk(7));

        // R9: set and clear in the same cycle
        evt_align = 1; @(negedge clk); clr_evt();
        evt_ext = 1; spr_req = 1; spr_we = 0; spr_addr = 10'd148;
        @(negedge clk);
        clr_evt(); spr_req = 0;
        check("R9 read returns old word", spr_rdata, bitk(7));
        do_read(10'd148);
        check("R9 new bit survives", spr_rdata, bitk(6));

        // R11: selective enable
        dbg_en = 1;
        load_den(bitk(7));
        evt_ext = 1; @(negedge clk); clr_evt();
        check("R11 disabled cause no req", {31'b0, dbg_req}, 32'h0);
        evt_align = 1; @(negedge clk); clr_evt();
        check("R11 enabled cause req", {31'b0, dbg_req}, 32'h1);
        do_read(10'd148);
        check("R11 both recorded", spr_rdata, bitk(6) | bitk(7));

        // R6: check stop with debug enabled goes to debug, no halt
        load_den(bitk(2));
        evt_mchk = 1; msr_me = 0; @(negedge clk); clr_evt();
        check("R6 no halt when enabled", {31'b0, chkstop_req}, 32'h0);
        check("R6 debug instead", {31'b0, dbg_req}, 32'h1);
        do_read(10'd148);

        // R1: reset in mid-run clears recorded causes
        evt_ext = 1; evt_align = 1; @(negedge clk); clr_evt();
        rst_n = 0; @(negedge clk); rst_n = 1;
        do_read(10'd148);
        check("R1 reset clears word", spr_rdata, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule